// File: doc/BRIEF.md
# Ping-Pong Bank Write Controller

This block takes a stream of event words, each event closed by an end marker, and writes the words into one of two memory banks. While the writer fills one bank, a host empties the other. The two banks swap roles so that data can be taken without a break. A bank is closed only where an event ends, unless it has no room left. Two things close a bank: the fill count reaching a threshold that software programs, or a read request from the host. When a bank is closed it is marked full. The writer moves to the other bank as soon as that bank is no longer full.

The writer and the host share a small register region, called the mailbox. It holds a stored-event counter, a page flag that shows which banks are ready for reading and which bank is active, the almost-full threshold, a free-running heartbeat and a command register. Data taking starts only when the host writes the value 4 to the command register. Event data is placed above a fixed base word address in each bank, so it never lands on the mailbox region. The host returns a bank by pulsing that bank's drained line. If both banks are full, the writer drops its ready output and stalls the stream until a bank is returned.

Top module: `pingpong_writer`

## Requirements
- R1: After reset, `in_ready` and `bank_we` are low, both full flags are clear, the active bank is bank 0, and the event counter, heartbeat and command register read zero.
- R2: Words are stored only while the command register (byte address 0x50) holds the value 4. For any other value, `in_ready` is low and no write strobe is raised.
- R3: An accepted word is written to the active bank only, with one strobe bit (bit 0 for bank 0, bit 1 for bank 1), at word address `DATA_BASE` plus the count of words already in that bank. No write goes below `DATA_BASE`.
- R4: An accepted end-marked word that brings the bank's word count to at least the threshold (byte address 0x30) closes the bank: its full flag is set after that edge. One cycle later the writer moves to the other bank if that bank is not full, and continues from `DATA_BASE`.
- R5: A pulse on `host_rd_req` closes the active bank when the event in progress ends. If the request arrives between events and the bank holds words, the bank closes on the next edge. If the bank is empty, the request waits for the next stored end marker.
- R6: While the active bank is full and the other bank is also full, `in_ready` is low and no word is written. A pulse on `bank_drained[b]` clears bank b's full flag, and the writer then resumes in that bank.
- R7: A word that fills the last free slot of a bank (`2**ADDR_W - DATA_BASE` words) closes the bank even in the middle of an event. The rest of the event goes on in the other bank.
- R8: The event counter at byte address 0x20 rises by one for each accepted end-marked word, and for nothing else.
- R9: The heartbeat at byte address 0x40 counts up by one every `HB_DIV` clock cycles from reset release, whether or not data taking has started.
- R10: The page flag at byte address 0x2c reads the full flags in bits 1:0 and the active bank in bit 8. The threshold reads back at 0x30, the command register at 0x50, and every other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream word present |
| in_data | input | DATA_W | Stream word |
| in_last | input | 1 | Word ends its event |
| in_ready | output | 1 | Word is accepted this cycle when valid |
| bank_we | output | 2 | Per-bank write strobe |
| bank_addr | output | ADDR_W | Word address within the bank |
| bank_wdata | output | DATA_W | Write data |
| host_wr | input | 1 | Mailbox register write |
| host_addr | input | 8 | Mailbox byte address |
| host_wdata | input | 32 | Mailbox write data |
| host_rdata | output | 32 | Mailbox read data for `host_addr` |
| host_rd_req | input | 1 | Host asks for the current bank to be closed |
| bank_drained | input | 2 | Host has emptied the bank (pulse per bank) |
| bank_full | output | 2 | Bank closed and waiting to be read |
| active_bank | output | 1 | Bank currently being written |

## Verification
The stream is tried in five ways:
- Short events with a low threshold and frequent drains. These check threshold closes and immediate hand-over.
- Long events with the threshold above capacity. These separate a capacity close from a threshold close.
- Host requests placed mid-event, between events and on an empty bank. These separate the three request cases.
- A phase with no drains. This fills both banks and checks the stall, then the release when a bank is returned.
- A random mix of all of the above.

Before data taking starts, command values other than 4 are tried, to show that only 4 enables storage. Every mailbox address, including an unmapped one, is read in turn. This keeps the event count, heartbeat and page flag under continuous comparison.

// File: rtl/pingpong_writer.sv
module pingpong_writer #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int DATA_BASE = 32,
  parameter int THR_RST   = 64,
  parameter int HB_DIV    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic [1:0]        bank_we,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0] bank_wdata,
  input  logic              host_wr,
  input  logic [7:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              host_rd_req,
  input  logic [1:0]        bank_drained,
  output logic [1:0]        bank_full,
  output logic              active_bank
);
  localparam int CAP = (1 << ADDR_W) - DATA_BASE;
  localparam int PW  = $clog2(HB_DIV);
  localparam logic [7:0] A_EVT  = 8'h20;
  localparam logic [7:0] A_PAGE = 8'h2c;
  localparam logic [7:0] A_THR  = 8'h30;
  localparam logic [7:0] A_HB   = 8'h40;
  localparam logic [7:0] A_CMD  = 8'h50;

  logic              act, in_ev, req;
  logic [1:0]        full;
  logic [ADDR_W-1:0] wptr, thr;
  logic [31:0]       cmd, evcnt, hb;
  logic [PW-1:0]     pre;

  wire running = (cmd == 32'd4);
  wire store   = in_valid && in_ready;
  wire [ADDR_W:0] cnt1 = {1'b0, wptr} + 1'b1;
  wire at_cap  = (cnt1 == (ADDR_W+1)'(CAP));
  wire close   = store ? ((in_last && (cnt1 >= {1'b0, thr} || req)) || at_cap)
                       : (req && !in_ev && wptr != '0 && !full[act]);
  wire swap    = full[act] && !full[~act];

  assign in_ready    = running && !full[act];
  assign bank_we     = {act, ~act} & {2{store}};
  assign bank_addr   = ADDR_W'(DATA_BASE) + wptr;
  assign bank_wdata  = in_data;
  assign bank_full   = full;
  assign active_bank = act;

  always_comb begin
    case (host_addr)
      A_EVT:   host_rdata = evcnt;
      A_PAGE:  host_rdata = {23'd0, act, 6'd0, full};
      A_THR:   host_rdata = 32'(thr);
      A_HB:    host_rdata = hb;
      A_CMD:   host_rdata = cmd;
      default: host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      full  <= '0;
      wptr  <= '0;
      in_ev <= 1'b0;
      req   <= 1'b0;
      cmd   <= '0;
      thr   <= ADDR_W'(THR_RST);
      evcnt <= '0;
      hb    <= '0;
      pre   <= '0;
    end else begin
      if (swap) act <= ~act;
      if (close) wptr <= '0;
      else if (store) wptr <= cnt1[ADDR_W-1:0];
      for (int b = 0; b < 2; b++) begin
        if (close && act == b[0]) full[b] <= 1'b1;
        else if (bank_drained[b]) full[b] <= 1'b0;
      end
      if (host_rd_req) req <= 1'b1;
      else if (close) req <= 1'b0;
      if (store) in_ev <= !in_last;
      if (store && in_last) evcnt <= evcnt + 1'b1;
      if (pre == PW'(HB_DIV - 1)) begin
        pre <= '0;
        hb  <= hb + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      if (host_wr && host_addr == A_CMD) cmd <= host_wdata;
      if (host_wr && host_addr == A_THR) thr <= host_wdata[ADDR_W-1:0];
    end
  end

  assert_mbx_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_we) |-> (bank_addr >= ADDR_W'(DATA_BASE)));
  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
  assert_no_full_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we & bank_full) == 2'b00);
  assert_stop_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_CMD && host_wdata != 32'd4) |=> (bank_we == 2'b00));
  assert_hb_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hb == $past(hb) || hb == $past(hb) + 32'd1));
  assert_evcnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evcnt == $past(evcnt)) ||
             (evcnt == $past(evcnt) + 32'd1 && $past((|bank_we) && in_last)));
  assert_vacate_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full[act] && !full[~act]) |=> (act != $past(act)));
endmodule

// File: tb/pingpong_writer_tb.sv
module pingpong_writer_tb;
  localparam int DW = 32, AW = 7, DB = 32, THR0 = 40, HBD = 5;
  localparam int CAP = (1 << AW) - DB;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, host_wr = 0, host_rd_req = 0;
  logic [DW-1:0] in_data = '0;
  logic [7:0] host_addr = 8'h20;
  logic [31:0] host_wdata = '0;
  logic [1:0] bank_drained = '0;
  logic in_ready, active_bank;
  logic [1:0] bank_we, bank_full;
  logic [AW-1:0] bank_addr;
  logic [DW-1:0] bank_wdata;
  logic [31:0] host_rdata;

  pingpong_writer #(.DATA_W(DW), .ADDR_W(AW), .DATA_BASE(DB), .THR_RST(THR0), .HB_DIV(HBD)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rd_req(host_rd_req), .bank_drained(bank_drained), .bank_full(bank_full),
    .active_bank(active_bank));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, rd_idx = 0;
  string ph = "R2";
  bit acc;
  int m_act, m_wptr, m_inev, m_req, m_thr, m_pre;
  bit [1:0] m_full;
  bit [31:0] m_cmd, m_ev, m_hb;
  logic [7:0] rd_list [6] = '{8'h20, 8'h2c, 8'h30, 8'h40, 8'h50, 8'h14};

  task automatic check(bit ok, string tag, string what, longint act_v, longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act_v, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected under %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    bit rdy, st, cl, sw;
    int cnt1, exp_rd;
    bit [1:0] nf;
    string rtag;
    if (!host_wr) begin
      host_addr = rd_list[rd_idx];
      rd_idx = (rd_idx + 1) % 6;
    end
    #1;
    rdy = (m_cmd == 32'd4) && !m_full[m_act];
    st = in_valid && rdy;
    check(in_ready == rdy, ph, "in_ready", in_ready, rdy);
    check(bank_we == (st ? (2'b01 << m_act) : 2'b00), "R3", "bank_we", bank_we, st ? (1 << m_act) : 0);
    if (st) begin
      check(bank_addr == AW'(DB + m_wptr), "R3", "bank_addr", bank_addr, DB + m_wptr);
      check(bank_wdata == in_data, "R3", "bank_wdata", bank_wdata, in_data);
    end
    check(bank_full == m_full, ph, "bank_full", bank_full, m_full);
    check(active_bank == m_act[0], ph, "active_bank", active_bank, m_act);
    case (host_addr)
      8'h20: begin exp_rd = m_ev; rtag = "R8"; end
      8'h2c: begin exp_rd = (m_act << 8) | m_full; rtag = "R10"; end
      8'h30: begin exp_rd = m_thr; rtag = "R10"; end
      8'h40: begin exp_rd = m_hb; rtag = "R9"; end
      8'h50: begin exp_rd = m_cmd; rtag = "R10"; end
      default: begin exp_rd = 0; rtag = "R10"; end
    endcase
    check(host_rdata == 32'(exp_rd), rtag, "host_rdata", host_rdata, exp_rd);
    cnt1 = m_wptr + 1;
    if (st) cl = (in_last && (cnt1 >= m_thr || m_req != 0)) || cnt1 == CAP;
    else cl = m_req != 0 && m_inev == 0 && m_wptr != 0 && !m_full[m_act];
    sw = m_full[m_act] && !m_full[1 - m_act];
    nf = m_full;
    for (int b = 0; b < 2; b++) begin
      if (cl && m_act == b) nf[b] = 1'b1;
      else if (bank_drained[b]) nf[b] = 1'b0;
    end
    if (sw) m_act = 1 - m_act;
    m_full = nf;
    if (cl) m_wptr = 0; else if (st) m_wptr = cnt1;
    if (host_rd_req) m_req = 1; else if (cl) m_req = 0;
    if (st) m_inev = in_last ? 0 : 1;
    if (st && in_last) m_ev++;
    if (m_pre == HBD - 1) begin m_pre = 0; m_hb++; end else m_pre++;
    if (host_wr && host_addr == 8'h50) m_cmd = host_wdata;
    if (host_wr && host_addr == 8'h30) m_thr = host_wdata % (1 << AW);
    acc = st;
    @(negedge clk);
    host_wr = 0; host_rd_req = 0; bank_drained = 0;
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    step();
  endtask

  task automatic idle(int n, int drain_pct);
    in_valid = 0;
    for (int i = 0; i < n; i++) begin
      if (($urandom % 100) < drain_pct) bank_drained = 2'($urandom);
      step();
    end
  endtask

  task automatic send_event(int len, int drain_pct, int req_at);
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = $urandom; in_last = (i == len - 1);
      acc = 0;
      for (int w = 0; w < 400 && !acc; w++) begin
        if (($urandom % 100) < drain_pct) bank_drained = 2'($urandom);
        if (i == req_at) host_rd_req = 1;
        step();
      end
    end
    in_valid = 0; in_last = 0;
  endtask

  initial begin
    m_act = 0; m_wptr = 0; m_inev = 0; m_req = 0; m_thr = THR0; m_pre = 0;
    m_full = 0; m_cmd = 0; m_ev = 0; m_hb = 0;
    in_valid = 1;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 0 && bank_we == 0, "R1", "ready/we in reset", {in_ready, bank_we}, 0);
    check(bank_full == 0 && active_bank == 0, "R1", "full/active in reset", {bank_full, active_bank}, 0);
    check(host_rdata == 0, "R1", "event counter in reset", host_rdata, 0);
    @(negedge clk);
    rst_n = 1;
    ph = "R2";
    for (int i = 0; i < 6; i++) begin in_last = i[0]; step(); end
    hwrite(8'h50, 32'd3);
    for (int i = 0; i < 6; i++) step();
    hwrite(8'h50, 32'd5);
    for (int i = 0; i < 4; i++) step();
    hwrite(8'h50, 32'd4);
    in_valid = 1; in_last = 0;
    for (int i = 0; i < 4; i++) step();
    hwrite(8'h50, 32'd0);
    for (int i = 0; i < 4; i++) step();
    hwrite(8'h50, 32'd4);
    ph = "R4";
    hwrite(8'h30, 32'd10);
    for (int e = 0; e < 60; e++) begin
      send_event(1 + $urandom % 6, 12, -1);
      if ($urandom % 3 == 0) idle(1 + $urandom % 3, 12);
    end
    ph = "R5";
    hwrite(8'h30, 32'd127);
    bank_drained = 2'b11; idle(3, 0);
    send_event(5, 0, 2);
    idle(3, 0);
    bank_drained = 2'b11; idle(2, 0);
    send_event(4, 0, -1);
    idle(2, 0);
    host_rd_req = 1; idle(4, 0);
    bank_drained = 2'b11; idle(2, 0);
    host_rd_req = 1; idle(5, 0);
    send_event(2, 0, -1);
    idle(3, 0);
    ph = "R6";
    bank_drained = 2'b11; idle(2, 0);
    hwrite(8'h30, 32'd5);
    in_valid = 1;
    for (int i = 0; i < 40; i++) begin in_data = $urandom; in_last = (i % 3 == 2); step(); end
    in_valid = 0;
    idle(3, 0);
    bank_drained = 2'b01; idle(3, 0);
    bank_drained = 2'b10; idle(3, 0);
    ph = "R7";
    hwrite(8'h30, 32'd127);
    bank_drained = 2'b11; idle(3, 0);
    send_event(130, 3, -1);
    send_event(100, 3, 50);
    ph = "R3";
    hwrite(8'h30, 32'd20);
    for (int e = 0; e < 150; e++) begin
      send_event(1 + $urandom % 30, 6, ($urandom % 8 == 0) ? 0 : -1);
      if ($urandom % 4 == 0) idle(1 + $urandom % 4, 6);
      if ($urandom % 20 == 0) hwrite(8'h30, $urandom % 128);
    end
    idle(10, 50);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule